// File: doc/BRIEF.md
# Masked 3x3 Matrix Execution Unit

This block is a small execution unit for neighbourhood image filters. It holds three nine-element matrices of 16-bit pixels: a source matrix loaded from a parallel input, a working matrix, and a saved copy of the working matrix. A 9-bit element-enable mask gates every matrix-wide operation. Commands arrive on a command port, one per cycle, and each finishes in the cycle it is issued.

The usual flow builds a weighted 3x3 filter without multipliers. Per-element shift amounts are written into the working matrix and saved into the copy. The source pixels are then shifted right by those amounts into the working matrix, and one summing reduction produces the filtered pixel. The same reduction path also returns the maximum, minimum or median of the enabled elements. Reduction results are registered and appear one cycle after the command. Element i sits at row i/3, column i%3, and is carried on the flat matrix ports at bits [16*i+15 : 16*i].

Top module: `masked_mat_alu`

## Requirements
- R1: After reset the mask is 0x1FF, all three matrices and both configuration words are zero, and `res_valid` is low.
- R2: Command 1 (mask set) loads `cmd_arg[8:0]` into the mask, with bit i enabling element i. Every other command leaves the mask unchanged.
- R3: Command 2 (masked move) writes `cmd_arg` into each working-matrix element whose mask bit is 1 and leaves the other elements unchanged.
- R4: Command 3 (element write) writes `cmd_arg` into working element `cmd_idx` whatever the mask holds. An index of 9 to 15 changes nothing.
- R5: Command 4 (save) copies the working matrix into the saved matrix and leaves the working matrix unchanged. The saved matrix changes on no other command.
- R6: Command 6 (load) copies all nine elements of `ina_in` into the source matrix, ignoring the mask.
- R7: Command 5 (shift) sets each enabled working element to the source element shifted right by bits [3:0] of the saved element in the same position. The shift is arithmetic when bit 0 of the ALU configuration (command 7, word from `cmd_arg[1:0]`) is 1 and logical when it is 0. Disabled elements keep their values.
- R8: Command 9 (reduce) with `cmd_arg[1:0]` = 1, 2 or 3 returns the maximum, the minimum or the median of the enabled working elements. Values are compared as signed numbers when ALU configuration bit 0 is 1. For an even count the median is the lower of the two middle values. With an empty mask the result is 0.
- R9: Reduce with `cmd_arg[1:0]` = 0 returns (sum of the enabled elements × scale) >> shift. The fields come from the adder configuration (command 8, word `cmd_arg`): bit 3 makes the elements and the sum signed, bits [8:5] hold the shift and bits [15:9] hold the unsigned scale. The shift is arithmetic.
- R10: When ALU configuration bit 1 is 1, the scaled sum is clipped to [-32768, 32767] if signed or to [0, 65535] if unsigned. When that bit is 0 the low 16 bits are returned.
- R11: `res_valid` is high for exactly the one cycle after a reduce command. `res_data` holds the last result until the next reduce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code |
| cmd_arg | input | 16 | Scalar, mask, configuration word or reduction select |
| cmd_idx | input | 4 | Element index for the element write |
| ina_in | input | 144 | Source matrix to load, element i at [16*i+15:16*i] |
| mask_o | output | 9 | Current element-enable mask |
| w_o | output | 144 | Working matrix |
| ww_o | output | 144 | Saved matrix |
| res_valid | output | 1 | Reduction result strobe |
| res_data | output | 16 | Reduction result |

## Verification
Mask gating is swept over all 512 masks, once with masked moves and once with every order-statistic reduction in both signedness modes. A matrix holding duplicates, both extremes and negative codes separates signed ordering from unsigned ordering and shows the tie rules. Scaled sums run over a grid of shifts, scales, signedness, saturation and masks, which separates clipping from wrapping and arithmetic shifting from logical shifting. A shift-matrix run reproduces a 1-2-1 Gaussian kernel, and the element write is tried with a zero mask and with indices out of range.

// File: rtl/mat_alu_pkg.sv
package mat_alu_pkg;
    localparam int NEL = 9;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_MSET = 4'd1,
        OP_MOVM = 4'd2,
        OP_MOVE = 4'd3,
        OP_SWAP = 4'd4,
        OP_LSR  = 4'd5,
        OP_LDA  = 4'd6,
        OP_CALU = 4'd7,
        OP_CADD = 4'd8,
        OP_RED  = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        RED_SUM = 2'd0,
        RED_MAX = 2'd1,
        RED_MIN = 2'd2,
        RED_MED = 2'd3
    } red_e;
endpackage

// File: rtl/mat_rank_sel.sv
module mat_rank_sel #(
    parameter int DW  = 16,
    parameter int NEL = 9
) (
    input  logic [NEL*DW-1:0] vals,
    input  logic [NEL-1:0]    en,
    input  logic              sgn,
    input  logic [1:0]        sel,
    output logic [DW-1:0]     res
);
    localparam int CW = $clog2(NEL + 1);

    logic [NEL-1:0][DW-1:0] v;
    logic [NEL-1:0][CW-1:0] rank;
    logic [CW-1:0]          cnt_d;
    logic [CW-1:0]          tgt_d;

    assign v = vals;

    function automatic logic below(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                   input logic s);
        logic r;
        if (s) r = $signed(a) < $signed(b);
        else   r = a < b;
        return r;
    endfunction

    always_comb begin
        cnt_d = CW'($countones(en));
        case (sel)
            2'd1:    tgt_d = cnt_d - CW'(1);
            2'd3:    tgt_d = (cnt_d - CW'(1)) >> 1;
            default: tgt_d = '0;
        endcase
        res = '0;
        for (int i = 0; i < NEL; i++) begin
            rank[i] = '0;
            for (int j = 0; j < NEL; j++) begin
                if (en[j] && (j != i) &&
                    (below(v[j], v[i], sgn) || ((v[j] == v[i]) && (j < i))))
                    rank[i] = rank[i] + CW'(1);
            end
            if (en[i] && (rank[i] == tgt_d))
                res = v[i];
        end
    end
endmodule

// File: rtl/mat_scaled_sum.sv
module mat_scaled_sum #(
    parameter int DW  = 16,
    parameter int NEL = 9,
    parameter int SHW = 4,
    parameter int SCW = 7
) (
    input  logic [NEL*DW-1:0] vals,
    input  logic [NEL-1:0]    en,
    input  logic              sgn,
    input  logic              sat,
    input  logic [SHW-1:0]    shamt,
    input  logic [SCW-1:0]    scale,
    output logic [DW-1:0]     res
);
    localparam int SW = DW + $clog2(NEL) + 1;
    localparam int PW = SW + SCW + 1;
    localparam logic signed [PW-1:0] SMAX = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] SMIN = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic signed [PW-1:0] UMAX = {{(PW-DW){1'b0}}, {DW{1'b1}}};

    logic [NEL-1:0][DW-1:0] v;
    logic [SW-1:0]          acc_d;
    logic signed [PW-1:0]   prod_d;
    logic signed [PW-1:0]   shd_d;

    assign v = vals;

    always_comb begin
        acc_d = '0;
        for (int i = 0; i < NEL; i++) begin
            if (en[i])
                acc_d = acc_d + {{(SW-DW){sgn & v[i][DW-1]}}, v[i]};
        end
        prod_d = $signed({{(PW-SW){acc_d[SW-1]}}, acc_d}) *
                 $signed({{(PW-SCW){1'b0}}, scale});
        shd_d  = prod_d >>> shamt;
        res    = shd_d[DW-1:0];
        if (sat) begin
            if (sgn) begin
                if (shd_d > SMAX)      res = SMAX[DW-1:0];
                else if (shd_d < SMIN) res = SMIN[DW-1:0];
            end else if (shd_d > UMAX) begin
                res = UMAX[DW-1:0];
            end
        end
    end
endmodule

// File: rtl/masked_mat_alu.sv
module masked_mat_alu
    import mat_alu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [DW-1:0]     cmd_arg,
    input  logic [3:0]        cmd_idx,
    input  logic [9*DW-1:0]   ina_in,
    output logic [8:0]        mask_o,
    output logic [9*DW-1:0]   w_o,
    output logic [9*DW-1:0]   ww_o,
    output logic              res_valid,
    output logic [DW-1:0]     res_data
);
    localparam int SHW     = $clog2(DW);
    localparam int SCW     = DW - 9;
    localparam int SGN_BIT = 3;
    localparam int SH_LSB  = 5;
    localparam int SC_LSB  = 9;

    typedef struct packed {
        logic [NEL-1:0]         mask;
        logic [NEL-1:0][DW-1:0] ina;
        logic [NEL-1:0][DW-1:0] w;
        logic [NEL-1:0][DW-1:0] ww;
        logic [1:0]             alu_cfg;
        logic [DW-1:0]          add_cfg;
        logic                   res_vld;
        logic [DW-1:0]          res;
    } st_t;

    st_t q, d;
    logic [DW-1:0] sum_r, rank_r, sh_v;

    mat_scaled_sum #(.DW(DW), .NEL(NEL), .SHW(SHW), .SCW(SCW)) u_sum (
        .vals  (q.w),
        .en    (q.mask),
        .sgn   (q.add_cfg[SGN_BIT]),
        .sat   (q.alu_cfg[1]),
        .shamt (q.add_cfg[SH_LSB +: SHW]),
        .scale (q.add_cfg[SC_LSB +: SCW]),
        .res   (sum_r)
    );

    mat_rank_sel #(.DW(DW), .NEL(NEL)) u_rank (
        .vals (q.w),
        .en   (q.mask),
        .sgn  (q.alu_cfg[0]),
        .sel  (cmd_arg[1:0]),
        .res  (rank_r)
    );

    always_comb begin
        d         = q;
        d.res_vld = 1'b0;
        sh_v      = '0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_MSET: d.mask = cmd_arg[NEL-1:0];
                OP_MOVM: begin
                    for (int i = 0; i < NEL; i++)
                        if (q.mask[i]) d.w[i] = cmd_arg;
                end
                OP_MOVE: begin
                    for (int i = 0; i < NEL; i++)
                        if (cmd_idx == 4'(i)) d.w[i] = cmd_arg;
                end
                OP_SWAP: d.ww = q.w;
                OP_LSR: begin
                    for (int i = 0; i < NEL; i++) begin
                        if (q.alu_cfg[0])
                            sh_v = $signed(q.ina[i]) >>> q.ww[i][SHW-1:0];
                        else
                            sh_v = q.ina[i] >> q.ww[i][SHW-1:0];
                        if (q.mask[i]) d.w[i] = sh_v;
                    end
                end
                OP_LDA: begin
                    for (int i = 0; i < NEL; i++)
                        d.ina[i] = ina_in[i*DW +: DW];
                end
                OP_CALU: d.alu_cfg = cmd_arg[1:0];
                OP_CADD: d.add_cfg = cmd_arg;
                OP_RED: begin
                    d.res_vld = 1'b1;
                    d.res     = (cmd_arg[1:0] == RED_SUM) ? sum_r : rank_r;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.mask <= '1;
        end else begin
            q <= d;
        end
    end

    assign mask_o    = q.mask;
    assign w_o       = q.w;
    assign ww_o      = q.ww;
    assign res_valid = q.res_vld;
    assign res_data  = q.res;
endmodule

// File: rtl/mat_alu_chk.sv
module mat_alu_chk
    import mat_alu_pkg::*;
#(
    parameter int DW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [3:0]      cmd_op,
    input logic [DW-1:0]   cmd_arg,
    input logic [8:0]      mask_o,
    input logic [9*DW-1:0] w_o,
    input logic [9*DW-1:0] ww_o,
    input logic            res_valid
);
    logic is_mset, is_movm, is_swap, is_red;
    assign is_mset = cmd_valid && (cmd_op == OP_MSET);
    assign is_movm = cmd_valid && (cmd_op == OP_MOVM);
    assign is_swap = cmd_valid && (cmd_op == OP_SWAP);
    assign is_red  = cmd_valid && (cmd_op == OP_RED);

    // R2
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_mset |=> mask_o == $past(cmd_arg[8:0]));
    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_mset |=> $stable(mask_o));
    // R5
    swap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_swap |=> (ww_o == $past(w_o)) && $stable(w_o));
    // R5
    ww_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_swap |=> $stable(ww_o));
    // R11
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_red |=> res_valid);
    // R11
    res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_red |=> !res_valid);

    for (genvar g = 0; g < 9; g++) begin : g_el
        // R3
        movm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (is_movm && !mask_o[g]) |=> $stable(w_o[g*DW +: DW]));
        // R3
        movm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (is_movm && mask_o[g]) |=> w_o[g*DW +: DW] == $past(cmd_arg));
    end
endmodule

bind masked_mat_alu mat_alu_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_arg   (cmd_arg),
    .mask_o    (mask_o),
    .w_o       (w_o),
    .ww_o      (ww_o),
    .res_valid (res_valid)
);

// File: tb/masked_mat_alu_bench.sv
module masked_mat_alu_bench;
    localparam logic [3:0] C_MSET = 4'd1, C_MOVM = 4'd2, C_MOVE = 4'd3, C_SWAP = 4'd4,
                           C_LSR = 4'd5, C_LDA = 4'd6, C_CALU = 4'd7, C_CADD = 4'd8,
                           C_RED = 4'd9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd_op = '0;
    logic [15:0]   cmd_arg = '0;
    logic [3:0]    cmd_idx = '0;
    logic [143:0]  ina_in = '0;
    logic [8:0]    mask_o;
    logic [143:0]  w_o, ww_o;
    logic          res_valid;
    logic [15:0]   res_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [15:0] wm[9], wwm[9], im[9];
    logic [8:0]  mm;
    logic [1:0]  acm;
    logic [15:0] dcm;

    always #5 clk = ~clk;

    masked_mat_alu u_masked_mat_alu (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .cmd_idx(cmd_idx), .ina_in(ina_in), .mask_o(mask_o),
        .w_o(w_o), .ww_o(ww_o), .res_valid(res_valid), .res_data(res_data)
    );

    task automatic chk(input string tag, input logic [143:0] got, input logic [143:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [143:0] pk(input logic [15:0] a[9]);
        logic [143:0] r;
        for (int i = 0; i < 9; i++) r[i*16 +: 16] = a[i];
        return r;
    endfunction

    function automatic longint sv(input logic [15:0] v, input bit s);
        return s ? longint'($signed(v)) : longint'(v);
    endfunction

    function automatic logic [15:0] exp_red(input logic [1:0] sel);
        logic [15:0] a[9];
        logic [15:0] t;
        int n = 0;
        longint s = 0, p;
        bit sg;
        if (sel == 2'd0) begin
            sg = dcm[3];
            for (int i = 0; i < 9; i++) if (mm[i]) s += sv(wm[i], sg);
            p = (s * longint'(dcm[15:9])) >>> dcm[8:5];
            if (acm[1]) begin
                if (sg && p > 32767) p = 32767;
                if (sg && p < -32768) p = -32768;
                if (!sg && p > 65535) p = 65535;
            end
            return p[15:0];
        end
        sg = acm[0];
        for (int i = 0; i < 9; i++) if (mm[i]) begin a[n] = wm[i]; n++; end
        if (n == 0) return 16'h0;
        for (int i = 0; i < n; i++)
            for (int j = 0; j < n - 1 - i; j++)
                if (sv(a[j], sg) > sv(a[j+1], sg)) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
        if (sel == 2'd1) return a[n-1];
        if (sel == 2'd2) return a[0];
        return a[(n-1)/2];
    endfunction

    logic [15:0] exp_res;

    task automatic cmd(input logic [3:0] op, input logic [15:0] arg, input logic [3:0] idx);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg; cmd_idx = idx;
        case (op)
            C_MSET: mm = arg[8:0];
            C_MOVM: for (int i = 0; i < 9; i++) if (mm[i]) wm[i] = arg;
            C_MOVE: if (idx < 9) wm[idx] = arg;
            C_SWAP: wwm = wm;
            C_LSR: for (int i = 0; i < 9; i++) if (mm[i]) begin
                if (acm[0]) wm[i] = 16'($signed(im[i]) >>> wwm[i][3:0]);
                else        wm[i] = im[i] >> wwm[i][3:0];
            end
            C_LDA: for (int i = 0; i < 9; i++) im[i] = ina_in[i*16 +: 16];
            C_CALU: acm = arg[1:0];
            C_CADD: dcm = arg;
            C_RED: exp_res = exp_red(arg[1:0]);
            default: ;
        endcase
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic set_w(input logic [15:0] v[9]);
        for (int i = 0; i < 9; i++) cmd(C_MOVE, v[i], 4'(i));
    endtask

    task automatic red(input logic [1:0] sel, input string tag);
        cmd(C_RED, {14'd0, sel}, 4'd0);
        chk({tag, " R11 valid"}, 144'(res_valid), 144'(1));
        chk(tag, 144'(res_data), 144'(exp_res));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R11 got=timeout exp=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] pat[9];
        logic [15:0] gw[9];
        logic [15:0] scl[5];
        logic [3:0]  shf[4];
        logic [8:0]  msk[4];
        for (int i = 0; i < 9; i++) begin wm[i] = 0; wwm[i] = 0; im[i] = 0; end
        mm = 9'h1FF; acm = 0; dcm = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mask", 144'(mask_o), 144'(9'h1FF));
        chk("R1 w", w_o, 144'd0);
        chk("R1 ww", ww_o, 144'd0);
        chk("R1 valid", 144'(res_valid), 144'd0);
        red(2'd0, "R1 zero config sum");

        // R2 R3 sweep over every mask
        for (int m = 0; m < 512; m++) begin
            cmd(C_MSET, 16'h1FF, 0);
            cmd(C_MOVM, 16'h1111, 0);
            cmd(C_MSET, 16'(m), 0);
            chk("R2 mask load", 144'(mask_o), 144'(m));
            cmd(C_MOVM, 16'hABCD ^ 16'(m), 0);
            chk("R3 masked move", w_o, pk(wm));
            chk("R2 mask held", 144'(mask_o), 144'(m));
        end

        // R4 element write ignores mask, bad index ignored
        cmd(C_MSET, 16'h000, 0);
        for (int i = 0; i < 9; i++) cmd(C_MOVE, 16'h0100 + 16'(i), 4'(i));
        chk("R4 element write", w_o, pk(wm));
        for (int i = 9; i < 16; i++) cmd(C_MOVE, 16'hDEAD, 4'(i));
        chk("R4 bad index", w_o, pk(wm));

        // R5 save
        cmd(C_SWAP, 0, 0);
        chk("R5 ww copy", ww_o, pk(wm));
        chk("R5 w kept", w_o, pk(wm));

        // R6 R7 load and shift, logical then arithmetic, then masked
        for (int i = 0; i < 9; i++) begin
            ina_in[i*16 +: 16] = (i % 2 == 0) ? 16'hF0F0 ^ 16'(i * 97) : 16'h7A5C + 16'(i);
            gw[i] = 16'(i + 3);
        end
        cmd(C_LDA, 0, 0);
        set_w(gw);
        cmd(C_SWAP, 0, 0);
        cmd(C_MSET, 16'h1FF, 0);
        for (int i = 0; i < 9; i++) gw[i] = 16'h5555;
        set_w(gw);
        cmd(C_LSR, 0, 0);
        chk("R6 R7 logical shift", w_o, pk(wm));
        cmd(C_CALU, 16'h1, 0);
        cmd(C_LSR, 0, 0);
        chk("R7 arithmetic shift", w_o, pk(wm));
        cmd(C_MSET, 16'h0AA, 0);
        set_w(gw);
        cmd(C_CALU, 16'h0, 0);
        cmd(C_LSR, 0, 0);
        chk("R7 masked shift", w_o, pk(wm));

        // R9 Gaussian 1-2-1 kernel via shifts and one sum
        for (int i = 0; i < 9; i++) ina_in[i*16 +: 16] = 16'(16 * (i + 1));
        cmd(C_LDA, 0, 0);
        gw = '{16'd4, 16'd3, 16'd4, 16'd3, 16'd2, 16'd3, 16'd4, 16'd3, 16'd4};
        set_w(gw);
        cmd(C_SWAP, 0, 0);
        cmd(C_MSET, 16'h1FF, 0);
        cmd(C_LSR, 0, 0);
        cmd(C_CADD, 16'h0200, 0);
        red(2'd0, "R9 gaussian sum");
        chk("R9 gaussian value", 144'(res_data), 144'd80);
        @(negedge clk);
        chk("R11 pulse drop", 144'(res_valid), 144'd0);
        chk("R11 data held", 144'(res_data), 144'd80);

        // R8 order statistics over all masks, both signedness modes
        pat = '{16'h8000, 16'h0005, 16'hFFFF, 16'h0005, 16'h7FFF,
                16'h0000, 16'h1234, 16'hFF00, 16'h0003};
        set_w(pat);
        for (int s = 0; s < 2; s++) begin
            cmd(C_CALU, 16'(s), 0);
            for (int m = 0; m < 512; m++) begin
                cmd(C_MSET, 16'(m), 0);
                red(2'd1, "R8 max");
                red(2'd2, "R8 min");
                red(2'd3, "R8 median");
            end
        end

        // R9 R10 scaled sum grid
        scl = '{7'd0, 7'd1, 7'd16, 7'd64, 7'd127};
        shf = '{4'd0, 4'd3, 4'd5, 4'd15};
        msk = '{9'h1FF, 9'h101, 9'h0AA, 9'h000};
        for (int sg = 0; sg < 2; sg++)
            for (int sa = 0; sa < 2; sa++) begin
                cmd(C_CALU, 16'(sa << 1), 0);
                for (int a = 0; a < 5; a++)
                    for (int b = 0; b < 4; b++) begin
                        cmd(C_CADD, {scl[a][6:0], shf[b], 1'b0, 1'(sg), 3'b000}, 0);
                        for (int c = 0; c < 4; c++) begin
                            cmd(C_MSET, 16'(msk[c]), 0);
                            red(2'd0, sa ? "R10 clipped sum" : "R9 R10 wrapped sum");
                        end
                    end
            end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule